// File: doc/BRIEF.md
# I2C Bit-Timing Calculator

This block turns an input clock frequency and a requested I2C bit rate into the timing values a bus controller needs. Both are unsigned 32-bit integers, sampled on a one-cycle start pulse. The block sorts the rate into a speed class, picks a glitch-filter width, and steps a clock prescaler upward from zero. At each step it divides the clock by the scaled bit rate, turns the quotient into a cycle budget, and splits that budget into a high time and a low time in the ratio 1:2.

The search stops at the first prescaler whose low time fits in six bits. The results are then placed in a timing word and a configuration word, and the block raises `done_o` for one cycle. A single sequential restoring divider serves every search step. The dividend is the clock shifted right by the prescaler, which gives the same floor as dividing by the scaled rate and cannot overflow.

If no prescaler fits, or the requested rate is zero, the block reports an error instead. Results stay on the outputs until the next completion.

Top module: `i2c_timing_calc`

## Requirements
- R1: `mode_o` gives the speed class of the sampled rate: 0 below 400000, 1 below 1000000, 2 below 3400000, 3 below 5000000, and 4 from 5000000 upward.
- R2: `filter_o` is 0 when the class is 3 or 4 and 2 for every other class.
- R3: For prescaler p, the cycle budget is floor(clock / (2^p * rate)) minus 3 minus half the filter width. The result is 0 when this subtraction would go below zero.
- R4: The high count is (budget + 2) / 3 and the low count is the budget minus the high count. `prescale_o` is the smallest p in 0..7 whose full-width low count is below 64, so a low count of exactly 64 makes the search move on to the next p.
- R5: When no p in 0..7 qualifies, `error_o` is 1 and the timing word, the configuration word and `prescale_o` are all zero.
- R6: The timing word holds the low count in bits [7:0] and the high count in bits [15:8]. Bits [23:16] repeat the high count as the setup/hold value, and bits [31:24] hold the high count shifted right by one.
- R7: The configuration word holds the prescaler in bits [2:0]. For class 4 only, bit 9 (ignore acknowledge) is 1 and bits [25:24] are 01; in every other class these bits are 0. All remaining bits are 0.
- R8: A rate of zero skips the search. `done_o` and `error_o` are high in the cycle after the start pulse is sampled, and the class and filter still follow R1 and R2.
- R9: A start pulse while `busy_o` is high is ignored. `done_o` is high for exactly one cycle per accepted request. The outputs change only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; samples both operands |
| clk_hz_i | input | 32 | Input clock frequency in Hz |
| bitrate_i | input | 32 | Requested bus bit rate in bit/s |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | No valid setting found, or rate was zero |
| mode_o | output | 3 | Speed class |
| filter_o | output | 4 | Glitch-filter width |
| prescale_o | output | 3 | Chosen prescaler exponent |
| timing_word_o | output | 32 | Packed low, high, setup/hold and data-valid counts |
| config_word_o | output | 32 | Packed prescaler, pin mode and ignore-acknowledge bit |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, a 3-bit prescaler and a low-count limit of 64. With these values the full eight-step search is reachable, including the case where every step fails, and an operand pair can be chosen so that the low count lands at exactly 63 or exactly 64. The chosen clock and rate pairs also cross every class boundary, drive the cycle budget into saturation at zero, and send a second start pulse into a request that is still running.

// File: rtl/i2c_tcalc_pkg.sv
package i2c_tcalc_pkg;

  typedef enum logic [2:0] {
    SPD_STD   = 3'd0,
    SPD_FAST  = 3'd1,
    SPD_FPLUS = 3'd2,
    SPD_HS    = 3'd3,
    SPD_ULTRA = 3'd4
  } speed_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DONE   = 2'd3
  } calc_st_e;

  localparam int unsigned LIM_STD   = 400000;
  localparam int unsigned LIM_FAST  = 1000000;
  localparam int unsigned LIM_FPLUS = 3400000;
  localparam int unsigned LIM_HS    = 5000000;

  localparam int FILT_W        = 4;
  localparam int FILT_NORMAL   = 2;
  localparam int FIXED_OVERHEAD = 3;

  localparam int CFG_IGNACK_BIT = 9;
  localparam int CFG_PIN_LSB    = 24;

endpackage

// File: rtl/i2c_tcalc_class.sv
module i2c_tcalc_class
  import i2c_tcalc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rate_i,
  output speed_e            spd_o,
  output logic [FILT_W-1:0] filt_o
);

  always_comb begin
    if (rate_i < DATA_W'(LIM_STD))        spd_o = SPD_STD;
    else if (rate_i < DATA_W'(LIM_FAST))  spd_o = SPD_FAST;
    else if (rate_i < DATA_W'(LIM_FPLUS)) spd_o = SPD_FPLUS;
    else if (rate_i < DATA_W'(LIM_HS))    spd_o = SPD_HS;
    else                                  spd_o = SPD_ULTRA;
  end

  always_comb begin
    if (spd_o == SPD_HS || spd_o == SPD_ULTRA) filt_o = '0;
    else                                       filt_o = FILT_W'(FILT_NORMAL);
  end

endmodule

// File: rtl/i2c_tcalc_div.sv
module i2c_tcalc_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         valid_o,
  output logic [W-1:0] quotient_o
);

  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, rem_d;
  logic [W-1:0]     quo_q, quo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             vld_q, vld_d;
  logic [W:0]       shifted;
  logic [W:0]       trial;

  assign shifted = {rem_q, quo_q[W-1]};
  assign trial   = shifted - {1'b0, divisor_i};

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    cnt_d = cnt_q;
    run_d = run_q;
    vld_d = 1'b0;
    if (start_i) begin
      rem_d = '0;
      quo_d = dividend_i;
      cnt_d = CNT_W'(W);
      run_d = 1'b1;
    end else if (run_q) begin
      if (!trial[W]) begin
        rem_d = trial[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = shifted[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run_d = 1'b0;
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
      vld_q <= vld_d;
    end
  end

  assign valid_o    = vld_q;
  assign quotient_o = quo_q;

endmodule

// File: rtl/i2c_tcalc_split.sv
module i2c_tcalc_split
  import i2c_tcalc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int FIELD_W  = 8,
  parameter int LO_LIMIT = 64
) (
  input  logic [DATA_W-1:0]  quot_i,
  input  logic [FILT_W-1:0]  filt_i,
  output logic [FIELD_W-1:0] hi_o,
  output logic [FIELD_W-1:0] lo_o,
  output logic               fits_o
);

  logic [DATA_W-1:0] deduct;
  logic [DATA_W-1:0] budget;
  logic [DATA_W-1:0] hi_full;
  logic [DATA_W-1:0] lo_full;
  logic              unused_upper;

  assign deduct  = DATA_W'(FIXED_OVERHEAD) + DATA_W'(filt_i >> 1);
  assign budget  = (quot_i >= deduct) ? (quot_i - deduct) : '0;
  assign hi_full = (budget + DATA_W'(2)) / DATA_W'(3);
  assign lo_full = budget - hi_full;
  assign fits_o  = lo_full < DATA_W'(LO_LIMIT);
  assign hi_o    = hi_full[FIELD_W-1:0];
  assign lo_o    = lo_full[FIELD_W-1:0];

  assign unused_upper = ^{hi_full[DATA_W-1:FIELD_W], lo_full[DATA_W-1:FIELD_W]};

endmodule

// File: rtl/i2c_timing_calc.sv
module i2c_timing_calc
  import i2c_tcalc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PS_W     = 3,
  parameter int FIELD_W  = 8,
  parameter int LO_LIMIT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] clk_hz_i,
  input  logic [31:0] bitrate_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        error_o,
  output logic [2:0]  mode_o,
  output logic [3:0]  filter_o,
  output logic [2:0]  prescale_o,
  output logic [31:0] timing_word_o,
  output logic [31:0] config_word_o
);

  localparam logic [PS_W-1:0] PS_LAST = '1;

  calc_st_e          st_q, st_d;
  logic [DATA_W-1:0] clkv_q, clkv_d;
  logic [DATA_W-1:0] rate_q, rate_d;
  logic [PS_W-1:0]   ps_q, ps_d;

  logic              res_en;
  logic              res_err;
  logic [31:0]       res_timing, res_cfg;
  logic [PS_W-1:0]   res_ps;

  logic              err_q;
  logic [31:0]       timing_q, cfg_q;
  logic [2:0]        mode_q;
  logic [FILT_W-1:0] filt_q;
  logic [PS_W-1:0]   pso_q;

  logic [DATA_W-1:0] class_rate;
  speed_e            spd;
  logic [FILT_W-1:0] filt;
  logic              div_start;
  logic              div_valid;
  logic [DATA_W-1:0] div_quot;
  logic [DATA_W-1:0] dividend;
  logic [FIELD_W-1:0] hi_cnt, lo_cnt;
  logic              fits;

  assign class_rate = (st_q == ST_IDLE) ? bitrate_i : rate_q;
  assign dividend   = clkv_q >> ps_q;

  i2c_tcalc_class #(.DATA_W(DATA_W)) u_class (
    .rate_i (class_rate),
    .spd_o  (spd),
    .filt_o (filt)
  );

  i2c_tcalc_div #(.W(DATA_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (div_start),
    .dividend_i (dividend),
    .divisor_i  (rate_q),
    .valid_o    (div_valid),
    .quotient_o (div_quot)
  );

  i2c_tcalc_split #(
    .DATA_W   (DATA_W),
    .FIELD_W  (FIELD_W),
    .LO_LIMIT (LO_LIMIT)
  ) u_split (
    .quot_i (div_quot),
    .filt_i (filt),
    .hi_o   (hi_cnt),
    .lo_o   (lo_cnt),
    .fits_o (fits)
  );

  always_comb begin
    st_d      = st_q;
    clkv_d    = clkv_q;
    rate_d    = rate_q;
    ps_d      = ps_q;
    div_start = 1'b0;
    res_en    = 1'b0;
    res_err   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          clkv_d = clk_hz_i;
          rate_d = bitrate_i;
          ps_d   = '0;
          if (bitrate_i == '0) begin
            res_en  = 1'b1;
            res_err = 1'b1;
            st_d    = ST_DONE;
          end else begin
            st_d = ST_LAUNCH;
          end
        end
      end
      ST_LAUNCH: begin
        div_start = 1'b1;
        st_d      = ST_WAIT;
      end
      ST_WAIT: begin
        if (div_valid) begin
          if (fits) begin
            res_en = 1'b1;
            st_d   = ST_DONE;
          end else if (ps_q == PS_LAST) begin
            res_en  = 1'b1;
            res_err = 1'b1;
            st_d    = ST_DONE;
          end else begin
            ps_d = ps_q + 1'b1;
            st_d = ST_LAUNCH;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    res_timing = '0;
    res_cfg    = '0;
    res_ps     = '0;
    if (!res_err) begin
      res_timing = {8'(hi_cnt >> 1), 8'(hi_cnt), 8'(hi_cnt), 8'(lo_cnt)};
      res_ps     = ps_q;
      res_cfg[PS_W-1:0] = ps_q;
      if (spd == SPD_ULTRA) begin
        res_cfg[CFG_IGNACK_BIT]                = 1'b1;
        res_cfg[CFG_PIN_LSB+1:CFG_PIN_LSB]     = 2'b01;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      clkv_q <= '0;
      rate_q <= '0;
      ps_q   <= '0;
    end else begin
      st_q   <= st_d;
      clkv_q <= clkv_d;
      rate_q <= rate_d;
      ps_q   <= ps_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= 1'b0;
      timing_q <= '0;
      cfg_q    <= '0;
      mode_q   <= '0;
      filt_q   <= '0;
      pso_q    <= '0;
    end else if (res_en) begin
      err_q    <= res_err;
      timing_q <= res_timing;
      cfg_q    <= res_cfg;
      mode_q   <= spd;
      filt_q   <= filt;
      pso_q    <= res_ps;
    end
  end

  assign busy_o        = (st_q != ST_IDLE);
  assign done_o        = (st_q == ST_DONE);
  assign error_o       = err_q;
  assign mode_o        = mode_q;
  assign filter_o      = filt_q;
  assign prescale_o    = 3'(pso_q);
  assign timing_word_o = timing_q;
  assign config_word_o = cfg_q;

endmodule

// File: rtl/i2c_tcalc_chk.sv
module i2c_tcalc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [31:0] bitrate_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        error_o,
  input logic [2:0]  mode_o,
  input logic [3:0]  filter_o,
  input logic [31:0] timing_word_o,
  input logic [31:0] config_word_o
);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({timing_word_o, config_word_o, error_o}) |-> done_o);

  p_zero_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && bitrate_i == 32'd0) |=> (done_o && error_o));

  p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && error_o) |-> (timing_word_o == 32'd0 && config_word_o == 32'd0));

  p_lo_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !error_o) |-> (timing_word_o[7:0] < 8'd64));

  p_pack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !error_o) |->
      (timing_word_o[23:16] == timing_word_o[15:8] &&
       timing_word_o[31:24] == {1'b0, timing_word_o[15:9]}));

  p_filter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (filter_o == ((mode_o >= 3'd3) ? 4'd0 : 4'd2)));

  p_ultra_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !error_o) |->
      (config_word_o[9] == (mode_o == 3'd4) &&
       config_word_o[25:24] == ((mode_o == 3'd4) ? 2'b01 : 2'b00)));

endmodule

bind i2c_timing_calc i2c_tcalc_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .bitrate_i     (bitrate_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .error_o       (error_o),
  .mode_o        (mode_o),
  .filter_o      (filter_o),
  .timing_word_o (timing_word_o),
  .config_word_o (config_word_o)
);

// File: tb/test_i2c_timing_calc.sv
`timescale 1ns/1ps
module test_i2c_timing_calc;

  typedef struct packed {
    logic [31:0] tw;
    logic [31:0] cw;
    logic [2:0]  md;
    logic [3:0]  fl;
    logic [2:0]  ps;
    logic        er;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] clk_hz_i;
  logic [31:0] bitrate_i;
  logic        busy_o, done_o, error_o;
  logic [2:0]  mode_o;
  logic [3:0]  filter_o;
  logic [2:0]  prescale_o;
  logic [31:0] timing_word_o, config_word_o;

  int   checks = 0;
  int   errors = 0;
  exp_t expq[$];
  logic prev_done = 1'b0;
  int   cyc = 0;

  i2c_timing_calc i_i2c_timing_calc (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .clk_hz_i      (clk_hz_i),
    .bitrate_i     (bitrate_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .error_o       (error_o),
    .mode_o        (mode_o),
    .filter_o      (filter_o),
    .prescale_o    (prescale_o),
    .timing_word_o (timing_word_o),
    .config_word_o (config_word_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t ref_model(input longint c, input longint b);
    exp_t e;
    longint q, bud, hi, lo;
    e = '0;
    if (b < 400000)       e.md = 3'd0;
    else if (b < 1000000) e.md = 3'd1;
    else if (b < 3400000) e.md = 3'd2;
    else if (b < 5000000) e.md = 3'd3;
    else                  e.md = 3'd4;
    e.fl = (e.md >= 3) ? 4'd0 : 4'd2;
    e.er = 1'b1;
    if (b == 0) return e;
    for (int p = 0; p < 8; p++) begin
      q   = c / ((longint'(1) << p) * b);
      bud = q - 3 - longint'(e.fl) / 2;
      if (bud < 0) bud = 0;
      hi  = (bud + 2) / 3;
      lo  = bud - hi;
      if (lo < 64) begin
        e.er = 1'b0;
        e.ps = 3'(p);
        e.tw = {8'(hi >> 1), 8'(hi), 8'(hi), 8'(lo)};
        e.cw = 32'(p);
        if (e.md == 3'd4) e.cw = e.cw | 32'h0100_0200;
        break;
      end
    end
    return e;
  endfunction

  // Reference comparison on every clock (sampled mid-cycle)
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o && prev_done)
        check(1'b0, "R9 done longer than one cycle", 1, 0);
      if (done_o) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(mode_o == e.md,        "R1 mode",        64'(mode_o), 64'(e.md));
          check(filter_o == e.fl,      "R2 filter",      64'(filter_o), 64'(e.fl));
          check(error_o == e.er,       "R5 error",       64'(error_o), 64'(e.er));
          check(prescale_o == e.ps,    "R4 prescale",    64'(prescale_o), 64'(e.ps));
          check(timing_word_o == e.tw, "R3 R6 timing",   64'(timing_word_o), 64'(e.tw));
          check(config_word_o == e.cw, "R7 config",      64'(config_word_o), 64'(e.cw));
        end
      end
      if (!busy_o && expq.size() != 0 && !done_o && !start_i)
        check(1'b0, "R9 idle with request pending", 0, 1);
      prev_done = done_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_case(input logic [31:0] c, input logic [31:0] b);
    while (busy_o) @(negedge clk);
    clk_hz_i  = c;
    bitrate_i = b;
    start_i   = 1'b1;
    expq.push_back(ref_model(longint'(c), longint'(b)));
    @(negedge clk);
    start_i = 1'b0;
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n     = 1'b0;
    start_i   = 1'b0;
    clk_hz_i  = '0;
    bitrate_i = '0;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !error_o, "R9 reset flags", {busy_o, done_o, error_o}, 0);
    check(timing_word_o == 0 && config_word_o == 0, "R6 R7 reset words",
          {timing_word_o, config_word_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_case(32'd24_000_000, 32'd100_000);   // R4 search reaches p=2
    run_case(32'd9_900_000,  32'd100_000);   // R4 low count 63 fits at p=0
    run_case(32'd10_000_000, 32'd100_000);   // R4 low count 64 forces p=1
    run_case(32'd48_000_000, 32'd399_999);   // R1 upper edge of class 0
    run_case(32'd48_000_000, 32'd400_000);   // R1 class 1
    run_case(32'd24_000_000, 32'd1_000_000); // R1 class 2
    run_case(32'd60_000_000, 32'd3_400_000); // R2 class 3 no filter
    run_case(32'd60_000_000, 32'd4_999_999); // R1 class 3 upper edge
    run_case(32'd60_000_000, 32'd5_000_000); // R7 class 4 config bits
    run_case(32'd1_000,      32'd100_000);   // R3 saturation to zero
    run_case(32'hFFFF_FFFF,  32'd1);         // R5 no prescaler fits

    // R8: zero rate completes in the cycle after sampling
    clk_hz_i  = 32'd24_000_000;
    bitrate_i = 32'd0;
    start_i   = 1'b1;
    expq.push_back(ref_model(24_000_000, 0));
    @(negedge clk);
    start_i = 1'b0;
    check(done_o && error_o, "R8 immediate error", {done_o, error_o}, 2'b11);
    repeat (2) @(negedge clk);

    // R9: start while busy ignored
    clk_hz_i  = 32'd24_000_000;
    bitrate_i = 32'd100_000;
    start_i   = 1'b1;
    expq.push_back(ref_model(24_000_000, 100_000));
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    check(busy_o, "R9 busy during search", busy_o, 1);
    clk_hz_i  = 32'd60_000_000;
    bitrate_i = 32'd5_000_000;
    start_i   = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (expq.size() != 0) @(negedge clk);
    repeat (300) @(negedge clk);
    check(!busy_o && !done_o, "R9 no second job", {busy_o, done_o}, 0);
    check(mode_o == 3'd0 && prescale_o == 3'd2, "R9 outputs from first job",
          {mode_o, prescale_o}, {3'd0, 3'd2});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule